// File: doc/BRIEF.md
# Tag Check Fault Mode Dispatcher

This block sits behind a memory tag checker and decides what a detected tag mismatch turns into. Each cycle may carry one fault event, with the faulting address, a write flag, a flag for user-level versus privileged access, and a flag saying whether the active translation regime has two address ranges. A 2-bit check-fault mode is picked from a small slice of a control register. User accesses use one field and privileged accesses use the other.

Depending on the mode, the event does one of three things:
- It is dropped.
- It raises a synchronous abort. The abort is a one-cycle pulse, registered together with the faulting address and a syndrome.
- It sets one bit of a two-bit sticky asynchronous fault flag.

In the mixed mode, stores take the asynchronous path and loads take the synchronous path.

The fault input is a plain one-cycle strobe. The block accepts an event in every cycle, so it has no back-pressure. The abort output is a registered pulse with no handshake: whoever takes exceptions must sample it in the cycle it is high.

Top module: `tcf_dispatch`

## Requirements
- R1: After reset, `abt_vld` is 0 and `async_flags` is 2'b00.
- R2: The mode is `chk_cfg[39:38]` when `flt_user` is 1, and `chk_cfg[41:40]` otherwise.
- R3: In mode 0, a fault event raises no abort and leaves `async_flags` unchanged.
- R4: In mode 1, a fault event makes `abt_vld` 1 on the next cycle, with `abt_addr` equal to the event's `flt_addr`.
- R5: In mode 2, a fault event sets an asynchronous flag bit on the next cycle and raises no abort.
- R6: In mode 3, a write fault sets an asynchronous flag bit and raises no abort, while a read fault raises an abort as in mode 1.
- R7: The flag bit that is set has index `flt_addr[55]` when `two_range` is 1, and index 0 otherwise.
- R8: `abt_syn[5:0]` is 6'h11 (the tag-check fault status code) and `abt_syn[6]` is the event's write flag.
- R9: A set flag bit stays set until its `async_clr` bit is 1. A clear takes effect on the next cycle. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: `abt_vld` is high for exactly one cycle per aborting event, and is 0 in the cycle after any cycle without a fault event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_vld | input | 1 | Fault event strobe |
| flt_addr | input | 64 | Faulting address |
| flt_wr | input | 1 | 1 = store, 0 = load |
| flt_user | input | 1 | 1 = user-level access |
| two_range | input | 1 | Regime has two address ranges |
| chk_cfg | input | 4 (bits 41:38) | Mode fields: [39:38] user, [41:40] privileged |
| async_clr | input | 2 | Per-bit clear of the asynchronous flags |
| abt_vld | output | 1 | Synchronous abort pulse |
| abt_addr | output | 64 | Address of the aborting fault |
| abt_syn | output | 7 | Abort syndrome: [6] write, [5:0] status code |
| async_flags | output | 2 | Sticky asynchronous fault flags |

## Verification
The assertions assume that `chk_cfg`, `flt_user` and `flt_wr` are stable and meaningful whenever `flt_vld` is high. They also assume that an active `async_clr` bit is not expected to win against a set of the same bit. The stickiness checks only claim persistence when no clear is applied.

The directed tasks keep within these assumptions:
- The configuration is changed only between events, at a falling edge.
- Every strobe lasts exactly one cycle.
- Clears are applied either alone, or deliberately together with a set, to exercise the set-wins rule.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  typedef enum logic [1:0] {
    TCF_OFF   = 2'd0,
    TCF_SYNC  = 2'd1,
    TCF_ASYNC = 2'd2,
    TCF_MIXED = 2'd3
  } tcf_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ABORT = 2'd1,
    ACT_FLAG  = 2'd2
  } tcf_act_e;

  localparam int FSC_W = 6;
  localparam logic [FSC_W-1:0] FSC_TAG = 6'h11;
  localparam int SYN_W = FSC_W + 1;

  function automatic logic [SYN_W-1:0] mk_syn(input logic wr);
    return {wr, FSC_TAG};
  endfunction

endpackage

// File: rtl/tcf_mode_sel.sv
module tcf_mode_sel
  import tcf_pkg::*;
#(
  parameter int USR_LSB = 38,
  parameter int PRV_LSB = 40
) (
  input  logic [PRV_LSB+1:USR_LSB] cfg,
  input  logic                     is_user,
  input  logic                     is_wr,
  output tcf_act_e                 act
);

  tcf_mode_e mode;

  always_comb begin
    mode = is_user ? tcf_mode_e'(cfg[USR_LSB +: 2]) : tcf_mode_e'(cfg[PRV_LSB +: 2]);
    unique case (mode)
      TCF_OFF:   act = ACT_NONE;
      TCF_SYNC:  act = ACT_ABORT;
      TCF_ASYNC: act = ACT_FLAG;
      TCF_MIXED: act = is_wr ? ACT_FLAG : ACT_ABORT;
      default:   act = ACT_NONE;
    endcase
  end

endmodule

// File: rtl/tcf_abort_reg.sv
module tcf_abort_reg
  import tcf_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_in,
  output logic              vld,
  output logic [ADDR_W-1:0] addr_q,
  output logic [SYN_W-1:0]  syn_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      addr_q <= '0;
      syn_q  <= '0;
    end else begin
      vld <= take;
      if (take) begin
        addr_q <= addr_in;
        syn_q  <= mk_syn(wr_in);
      end
    end
  end

endmodule

// File: rtl/tcf_async_flags.sv
module tcf_async_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  output logic [NFLAG-1:0] flags
);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/tcf_dispatch.sv
module tcf_dispatch
  import tcf_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int SEL_BIT = 55,
  parameter int USR_LSB = 38,
  parameter int PRV_LSB = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flt_vld,
  input  logic [ADDR_W-1:0]        flt_addr,
  input  logic                     flt_wr,
  input  logic                     flt_user,
  input  logic                     two_range,
  input  logic [PRV_LSB+1:USR_LSB] chk_cfg,
  input  logic [1:0]               async_clr,
  output logic                     abt_vld,
  output logic [ADDR_W-1:0]        abt_addr,
  output logic [SYN_W-1:0]         abt_syn,
  output logic [1:0]               async_flags
);

  localparam int NFLAG = 2;

  tcf_act_e         act;
  logic             flag_idx;
  logic [NFLAG-1:0] set_vec;
  logic             take_abort;

  tcf_mode_sel #(.USR_LSB(USR_LSB), .PRV_LSB(PRV_LSB)) u_sel (
    .cfg     (chk_cfg),
    .is_user (flt_user),
    .is_wr   (flt_wr),
    .act     (act)
  );

  always_comb begin
    flag_idx   = two_range & flt_addr[SEL_BIT];
    take_abort = flt_vld && (act == ACT_ABORT);
    set_vec    = '0;
    if (flt_vld && (act == ACT_FLAG)) set_vec[flag_idx] = 1'b1;
  end

  tcf_abort_reg #(.ADDR_W(ADDR_W)) u_abt (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take_abort),
    .addr_in (flt_addr),
    .wr_in   (flt_wr),
    .vld     (abt_vld),
    .addr_q  (abt_addr),
    .syn_q   (abt_syn)
  );

  tcf_async_flags #(.NFLAG(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (async_clr),
    .flags   (async_flags)
  );

endmodule

// File: rtl/tcf_dispatch_chk.sv
module tcf_dispatch_chk #(
  parameter int ADDR_W  = 64,
  parameter int SEL_BIT = 55,
  parameter int USR_LSB = 38,
  parameter int PRV_LSB = 40
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flt_vld,
  input logic [ADDR_W-1:0]        flt_addr,
  input logic                     flt_wr,
  input logic                     flt_user,
  input logic                     two_range,
  input logic [PRV_LSB+1:USR_LSB] chk_cfg,
  input logic [1:0]               async_clr,
  input logic                     abt_vld,
  input logic [ADDR_W-1:0]        abt_addr,
  input logic [6:0]               abt_syn,
  input logic [1:0]               async_flags
);

  logic [1:0] md;
  assign md = flt_user ? chk_cfg[USR_LSB +: 2] : chk_cfg[PRV_LSB +: 2];

  AST_SYNC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && md == 2'd1) |=> (abt_vld && abt_addr == $past(flt_addr))); // R4
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && md == 2'd0 && async_clr == 2'b00) |=> (!abt_vld && $stable(async_flags))); // R3
  AST_ASYNC_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && md == 2'd2) |=> (!abt_vld && async_flags != 2'b00)); // R5
  AST_MIXED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && md == 2'd3 && flt_wr) |=> !abt_vld); // R6
  AST_SYN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    abt_vld |-> abt_syn[5:0] == 6'h11); // R8
  AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_vld |=> !abt_vld); // R10
  AST_STICKY_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (async_flags[0] && !async_clr[0]) |=> async_flags[0]); // R9
  AST_STICKY_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (async_flags[1] && !async_clr[1]) |=> async_flags[1]); // R9

endmodule

bind tcf_dispatch tcf_dispatch_chk #(
  .ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .USR_LSB(USR_LSB), .PRV_LSB(PRV_LSB)
) u_chk (.*);

// File: tb/sim_tcf_dispatch.sv
`timescale 1ns/1ps
module sim_tcf_dispatch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_vld = 1'b0;
  logic [63:0] flt_addr = '0;
  logic        flt_wr = 1'b0;
  logic        flt_user = 1'b0;
  logic        two_range = 1'b0;
  logic [41:38] chk_cfg = '0;
  logic [1:0]  async_clr = '0;
  logic        abt_vld;
  logic [63:0] abt_addr;
  logic [6:0]  abt_syn;
  logic [1:0]  async_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tcf_dispatch u0 (.*);

  localparam logic [63:0] A_HI = 64'h0080_0000_0000_1230;
  localparam logic [63:0] A_LO = 64'h0000_7FFF_FFFF_0040;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] prv, input logic [1:0] usr);
    chk_cfg = {prv, usr};
  endtask

  task automatic fire(input logic usr, input logic wr, input logic tr,
                      input logic [63:0] a, input logic [1:0] clr);
    @(negedge clk);
    flt_vld = 1'b1; flt_user = usr; flt_wr = wr; two_range = tr; flt_addr = a; async_clr = clr;
    @(negedge clk);
    flt_vld = 1'b0; async_clr = 2'b00;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic clear(input logic [1:0] c);
    @(negedge clk); async_clr = c;
    @(negedge clk); async_clr = 2'b00;
  endtask

  task automatic t_reset();
    chk(abt_vld == 1'b0, "R1 abt_vld", 64'(abt_vld), 64'd0);
    chk(async_flags == 2'b00, "R1 flags", 64'(async_flags), 64'd0);
  endtask

  task automatic t_sync();
    set_cfg(2'd0, 2'd1);
    fire(1'b1, 1'b0, 1'b0, A_LO, 2'b00);
    chk(abt_vld == 1'b1, "R4 abort", 64'(abt_vld), 64'd1);
    chk(abt_addr == A_LO, "R4 addr", abt_addr, A_LO);
    chk(abt_syn == 7'h11, "R8 read syn", 64'(abt_syn), 64'h11);
    idle();
    chk(abt_vld == 1'b0, "R10 pulse", 64'(abt_vld), 64'd0);
    fire(1'b1, 1'b1, 1'b0, A_HI, 2'b00);
    chk(abt_syn == 7'h51, "R8 write syn", 64'(abt_syn), 64'h51);
    chk(abt_addr == A_HI, "R4 addr2", abt_addr, A_HI);
    idle();
    chk(abt_vld == 1'b0, "R10 idle", 64'(abt_vld), 64'd0);
  endtask

  task automatic t_field();
    set_cfg(2'd1, 2'd0);
    fire(1'b0, 1'b0, 1'b0, A_LO, 2'b00);
    chk(abt_vld == 1'b1, "R2 priv field", 64'(abt_vld), 64'd1);
    idle();
    fire(1'b1, 1'b0, 1'b0, A_LO, 2'b00);
    chk(abt_vld == 1'b0, "R2 user field", 64'(abt_vld), 64'd0);
    chk(async_flags == 2'b00, "R2 user flags", 64'(async_flags), 64'd0);
  endtask

  task automatic t_off();
    set_cfg(2'd0, 2'd0);
    fire(1'b0, 1'b1, 1'b1, A_HI, 2'b00);
    chk(abt_vld == 1'b0, "R3 no abort", 64'(abt_vld), 64'd0);
    chk(async_flags == 2'b00, "R3 no flag", 64'(async_flags), 64'd0);
  endtask

  task automatic t_async();
    set_cfg(2'd2, 2'd2);
    fire(1'b0, 1'b0, 1'b1, A_HI, 2'b00);
    chk(async_flags == 2'b10, "R7 bit55 high", 64'(async_flags), 64'd2);
    chk(abt_vld == 1'b0, "R5 no abort", 64'(abt_vld), 64'd0);
    clear(2'b11);
    chk(async_flags == 2'b00, "R9 clear", 64'(async_flags), 64'd0);
    fire(1'b1, 1'b0, 1'b1, A_LO, 2'b00);
    chk(async_flags == 2'b01, "R7 bit55 low", 64'(async_flags), 64'd1);
    clear(2'b11);
    fire(1'b0, 1'b1, 1'b0, A_HI, 2'b00);
    chk(async_flags == 2'b01, "R7 one range", 64'(async_flags), 64'd1);
    clear(2'b11);
  endtask

  task automatic t_mixed();
    set_cfg(2'd3, 2'd3);
    fire(1'b0, 1'b1, 1'b0, A_LO, 2'b00);
    chk(async_flags == 2'b01, "R6 write flag", 64'(async_flags), 64'd1);
    chk(abt_vld == 1'b0, "R6 write no abort", 64'(abt_vld), 64'd0);
    fire(1'b0, 1'b0, 1'b0, A_HI, 2'b00);
    chk(abt_vld == 1'b1, "R6 read abort", 64'(abt_vld), 64'd1);
    chk(abt_syn == 7'h11, "R6 read syn", 64'(abt_syn), 64'h11);
    chk(async_flags == 2'b01, "R6 flag kept", 64'(async_flags), 64'd1);
    clear(2'b11);
  endtask

  task automatic t_sticky();
    set_cfg(2'd2, 2'd2);
    fire(1'b0, 1'b0, 1'b1, A_HI, 2'b00);
    fire(1'b0, 1'b0, 1'b1, A_LO, 2'b00);
    idle(); idle(); idle();
    chk(async_flags == 2'b11, "R9 sticky", 64'(async_flags), 64'd3);
    clear(2'b01);
    chk(async_flags == 2'b10, "R9 partial clear", 64'(async_flags), 64'd2);
    fire(1'b0, 1'b0, 1'b1, A_HI, 2'b10);
    chk(async_flags == 2'b10, "R9 set wins", 64'(async_flags), 64'd2);
    clear(2'b11);
    chk(async_flags == 2'b00, "R9 full clear", 64'(async_flags), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_sync();
    t_field();
    t_off();
    t_async();
    t_mixed();
    t_sticky();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule